// File: doc/BRIEF.md
# Gated One-Shot Countdown Event Timer

This block is a single memory-mapped one-shot event timer. Software reaches it through a simple register port. It has a control register and a tick-count register. The control register holds a master enable, an interrupt mask and a write-one clear strobe. Writing a tick count starts a countdown. When the countdown runs out, a pending flag is set. The interrupt line shows that flag through the mask.

The master enable gates every state change. While it is clear, the counter holds its value, writes to the tick-count register are dropped, and the pending flag cannot be cleared. This lets a driver freeze the timer by writing zero to the control register. A driver acknowledges an event with two writes: first the enable alone, then the enable together with the clear strobe. To arm the timer, it writes the enable, then the tick count, then the enable together with the interrupt mask.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset, the enable, mask, counter, running state, pending flag, `irq_o` and `bus_rdata` are all zero.
- R2: The control register is at byte address 0x40. Bit 0 is the enable and bit 1 is the interrupt mask; both are stored on every write to it. Bit 4 is a clear strobe. A read returns bits 1:0 as stored, and every other bit, bit 4 included, reads as zero.
- R3: A write to byte address 0x44 loads the counter and starts the countdown only if the enable is set at that moment. If the enable is clear, the write changes nothing. A read of 0x44 returns the current counter value.
- R4: While the enable is set and the timer is running, the counter drops by one each clock. While the enable is clear, the counter and the running state hold, so writing zero to the control register stops the timer.
- R5: A countdown that reaches zero sets the pending flag and stops. The counter then stays at zero and does not wrap. After loading N, the pending flag becomes visible N+1 clocks after the loading edge, so loading zero sets it on the next clock.
- R6: `irq_o` is registered and equals the pending flag ANDed with the mask. Changing the mask hides or shows a pending event without losing it.
- R7: Writing 1 to bit 4 of the control register clears the pending flag only if the enable was already set before that write. If the enable is clear, the flag is unchanged. If an expiry and a clear happen on the same clock, the expiry wins.
- R8: Writes to any other address are ignored, and reads from any other address return zero.
- R9: `bus_rdata` is loaded only on a clock with `bus_rd` high. On other clocks it holds its last value. A read returns the state from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one per clock |
| bus_rd | input | 1 | Read strobe, one per clock |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that reads and writes never use the same clock. They also assume that a loaded tick count fits the counter width. The stimulus issues at most one access per clock. It keeps random tick counts below 40, so countdowns both finish and get interrupted by control writes. Random control writes use all combinations of the enable, mask and clear bits, so gated clears and frozen countdowns occur often. A reference model in the bench follows the requirement text and is compared on every clock.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int BIT_EN  = 0;
  localparam int BIT_IE  = 1;
  localparam int BIT_CLR = 4;

  typedef struct packed {
    logic ie;
    logic en;
  } tmr_ctrl_t;
endpackage

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
  import evt_tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h40,
  parameter logic [ADDR_W-1:0] VAL_OFS  = 'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  output tmr_ctrl_t         ctrl_q,
  output tmr_ctrl_t         ctrl_d,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr_req,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int CTRL_BITS = $bits(tmr_ctrl_t);

  logic              hit_ctrl, hit_val;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl = (bus_addr == CTRL_OFS);
  assign hit_val  = (bus_addr == VAL_OFS);

  always_comb begin
    ctrl_d = ctrl_q;
    if (bus_wr && hit_ctrl) begin
      ctrl_d.en = bus_wdata[BIT_EN];
      ctrl_d.ie = bus_wdata[BIT_IE];
    end
  end

  assign load     = bus_wr && hit_val && ctrl_q.en;
  assign load_val = bus_wdata[CNT_W-1:0];
  assign clr_req  = bus_wr && hit_ctrl && bus_wdata[BIT_CLR] && ctrl_q.en;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)     rd_mux[CTRL_BITS-1:0] = ctrl_q;
    else if (hit_val) rd_mux[CNT_W-1:0]     = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      bus_rdata <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  a_r2_clr_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_ctrl) |=> (bus_rdata[BIT_CLR] == 1'b0));
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/evt_tmr_count.sv
module evt_tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  logic at_zero;

  assign at_zero = (count == '0);
  assign expire  = en && running && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      running <= 1'b1;
    end else if (en && running) begin
      if (at_zero) running <= 1'b0;
      else         count   <= count - 1'b1;
    end
  end

  a_r4_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(count) && $stable(running)));
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !load) |=> (count == '0));
  a_r5_stop_after_expire: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> !running);
endmodule

// File: rtl/evt_tmr_irq.sv
module evt_tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic expire,
  input  logic clr_req,
  input  logic ie_d,
  output logic pend,
  output logic irq_o
);
  logic pend_d;

  always_comb begin
    pend_d = pend;
    if (expire)       pend_d = 1'b1;
    else if (clr_req) pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      pend  <= pend_d;
      irq_o <= pend_d && ie_d;
    end
  end

  a_r6_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> pend);
  a_r7_gated_clear: assert property (@(posedge clk) disable iff (rst)
    (!en && pend) |=> pend);
  a_r7_expire_wins: assert property (@(posedge clk) disable iff (rst)
    expire |=> pend);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h40,
  parameter logic [ADDR_W-1:0] VAL_OFS  = 'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic             load, clr_req, running, expire, pend;
  logic [CNT_W-1:0] load_val, count;

  evt_tmr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CTRL_OFS(CTRL_OFS), .VAL_OFS(VAL_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count),
    .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .load(load), .load_val(load_val),
    .clr_req(clr_req), .bus_rdata(bus_rdata)
  );

  evt_tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .load(load), .load_val(load_val),
    .count(count), .running(running), .expire(expire)
  );

  evt_tmr_irq u_irq (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .expire(expire),
    .clr_req(clr_req), .ie_d(ctrl_d.ie), .pend(pend), .irq_o(irq_o)
  );

  a_r3_load_only_enabled: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == VAL_OFS && !ctrl_q.en) |=>
      ($stable(count) && $stable(running)));
  a_r8_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != CTRL_OFS) |=> $stable(ctrl_q));
endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_CTRL = 8'h40;
  localparam logic [AW-1:0] A_VAL  = 8'h44;

  logic clk = 1'b0;
  logic rst;
  logic bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic irq_o;

  always #5 clk = ~clk;

  evt_timer u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  logic m_en, m_ie, m_run, m_pend, m_irq;
  logic [31:0] m_cnt, m_rd;

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    if (a == A_CTRL) return {30'd0, m_ie, m_en};
    if (a == A_VAL)  return m_cnt;
    return 32'd0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [AW-1:0] a,
                      input logic [31:0] d, input string tag);
    logic cw, ld, hit, clr;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    cw  = w && a == A_CTRL;
    ld  = w && a == A_VAL && m_en;
    hit = m_en && m_run && m_cnt == 0;
    clr = cw && d[4] && m_en;
    if (r) m_rd = exp_read(a);
    if (ld) begin m_cnt = d; m_run = 1'b1; end
    else if (m_en && m_run) begin
      if (m_cnt == 0) m_run = 1'b0; else m_cnt = m_cnt - 1;
    end
    if (hit) m_pend = 1'b1; else if (clr) m_pend = 1'b0;
    if (cw) begin m_en = d[0]; m_ie = d[1]; end
    m_irq = m_pend && m_ie;
    @(negedge clk);
    chk({31'd0, irq_o}, {31'd0, m_irq}, {tag, " irq"});
    chk(bus_rdata, m_rd, {tag, " rdata"});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 32'd0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [4];
    addrs[0] = A_CTRL; addrs[1] = A_VAL; addrs[2] = 8'h48; addrs[3] = 8'h00;
    void'($urandom(32'd20240611));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    {m_en, m_ie, m_run, m_pend, m_irq} = '0;
    m_cnt = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk({31'd0, irq_o}, 32'd0, "R1 irq");
    chk(bus_rdata, 32'd0, "R1 rdata");
    step(0, 1, A_CTRL, 0, "R1"); chk(bus_rdata, 32'd0, "R1 ctrl");
    step(0, 1, A_VAL, 0, "R1");  chk(bus_rdata, 32'd0, "R1 count");
    // R2 control bits, bit4 reads zero
    step(1, 0, A_CTRL, 32'hFFFF_FFEF, "R2");
    step(0, 1, A_CTRL, 0, "R2"); chk(bus_rdata, 32'd3, "R2 ctrl readback");
    step(1, 0, A_CTRL, 32'h13, "R2");
    step(0, 1, A_CTRL, 0, "R2"); chk(bus_rdata, 32'd3, "R2 clr reads zero");
    // R5 load 5: pending N+1 clocks after the load edge
    step(1, 0, A_VAL, 5, "R3");
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 8'h00, 0, "R5");
      chk({31'd0, irq_o}, 32'd0, "R5 early");
    end
    step(0, 0, 8'h00, 0, "R5"); chk({31'd0, irq_o}, 32'd1, "R5 fire");
    step(0, 1, A_VAL, 0, "R5"); chk(bus_rdata, 32'd0, "R5 no wrap");
    // R6 mask hides and shows pending
    step(1, 0, A_CTRL, 32'h01, "R6"); chk({31'd0, irq_o}, 32'd0, "R6 masked");
    step(1, 0, A_CTRL, 32'h03, "R6"); chk({31'd0, irq_o}, 32'd1, "R6 unmasked");
    // R7 clear blocked while enable clear
    step(1, 0, A_CTRL, 32'h02, "R7");
    step(1, 0, A_CTRL, 32'h12, "R7"); chk({31'd0, irq_o}, 32'd1, "R7 gated clear");
    step(1, 0, A_CTRL, 32'h03, "R7");
    step(1, 0, A_CTRL, 32'h13, "R7"); chk({31'd0, irq_o}, 32'd0, "R7 clear");
    // R4 freeze
    step(1, 0, A_VAL, 10, "R4");
    idle(2, "R4");
    step(1, 0, A_CTRL, 32'h00, "R4");
    idle(5, "R4");
    step(0, 1, A_VAL, 0, "R4"); chk(bus_rdata, 32'd7, "R4 frozen count");
    // R3 write while disabled ignored
    step(1, 0, A_VAL, 99, "R3");
    step(0, 1, A_VAL, 0, "R3"); chk(bus_rdata, 32'd7, "R3 ignored write");
    // R5 zero load fires next clock
    step(1, 0, A_CTRL, 32'h03, "R5");
    step(1, 0, A_VAL, 0, "R5");
    step(0, 0, 8'h00, 0, "R5"); chk({31'd0, irq_o}, 32'd1, "R5 zero load");
    // R8 unmapped
    step(1, 0, 8'h48, 32'hFFFF_FFFF, "R8");
    step(0, 1, 8'h48, 0, "R8"); chk(bus_rdata, 32'd0, "R8 unmapped read");
    // R9 hold
    idle(3, "R9"); chk(bus_rdata, 32'd0, "R9 hold");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2)      step(1, 0, A_CTRL, $urandom_range(0, 31), "R7");
      else if (op < 4) step(1, 0, A_VAL, $urandom_range(0, 39), "R3");
      else if (op < 6) step(0, 1, addrs[$urandom_range(0, 3)], 0, "R9");
      else if (op < 7) step(1, 0, 8'h48, $urandom, "R8");
      else             step(0, 0, 8'h00, 0, "R4");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule